// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single semaphore cell with a 16-bit count. Requesters reach it through a view code and a read strobe and a write strobe. A read in one of the two semaphore views takes the semaphore (P). It returns the count as it stood before the operation and lowers the count when the count is above zero. A write in either semaphore view releases the semaphore (V). It raises the count, which stops at 0xFFFF. A write carries no data.

In the waiting view, a P on an empty semaphore does not complete. The requester's id is added to a 64-bit parked set, and the response carries a parked flag instead of data. In the polling view, a P on an empty semaphore returns zero and changes nothing. Any V clears the whole parked set. When that set was not empty, the cell raises a one-cycle wake strobe and presents the set that was released.

Each response comes one cycle after its read strobe. A small response machine has three states:
- `RSP_IDLE`: no response this cycle.
- `RSP_DATA`: read data valid.
- `RSP_PARKED`: requester parked.

Every cycle, the machine moves to `RSP_PARKED` on a read that parks, to `RSP_DATA` on any other read, and to `RSP_IDLE` when there is no read. A mode input marks the cell as configured for queue use, which turns the semaphore views off.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0 and the parked set is empty. `rsp_valid_o`, `parked_o` and `wake_o` are low, and `rsp_data_o` and `wake_set_o` are 0.
- R2: A read with view code 4 or 5 on a nonzero count gives `rsp_valid_o`=1 in the next cycle, with `rsp_data_o` equal to the count before the read. The count drops by one.
- R3: A read with view code 5 on a zero count gives `rsp_valid_o`=1 and `rsp_data_o`=0 in the next cycle. The count and the parked set are left unchanged.
- R4: A read with view code 4 on a zero count gives `parked_o`=1, `rsp_valid_o`=0 and `rsp_data_o`=0 in the next cycle. Bit `req_id_i` of the parked set is set.
- R5: A write with view code 4 or 5 raises the count by one. It holds at 0xFFFF once it reaches that value.
- R6: A write with view code 4 or 5 empties the parked set. If the set was not empty, `wake_o` is high for exactly the next cycle and `wake_set_o` shows the set as it was. Otherwise `wake_o` stays low.
- R7: A read and a write in the same cycle with view code 4 or 5 are applied write first, then read. The read returns the count after the increment.
- R8: While `queue_mode_i`=1, reads with view code 4 or 5 return valid data 0 and leave the count unchanged, and writes with those codes are ignored.
- R9: A read with view code 0 returns the raw count with no change to it. A write with view code 0 is ignored.
- R10: A read with any other view code returns valid data 0, and a write with such a code is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| queue_mode_i | input | 1 | Cell configured for queue use; semaphore views disabled |
| view_i | input | 4 | View code: 0 raw, 4 waiting P/V, 5 polling P/V |
| rd_i | input | 1 | Read strobe (P in a semaphore view) |
| wr_i | input | 1 | Write strobe (V in a semaphore view) |
| req_id_i | input | 6 | Requester id |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_data_o | output | 16 | Read data, 0 when no data response |
| parked_o | output | 1 | Read parked the requester, one cycle after the read |
| wake_o | output | 1 | One-cycle strobe: parked requesters released |
| wake_set_o | output | 64 | Released requester set, 0 when `wake_o` is low |

## Verification
The embedded assertions check the following on every cycle:
- the count stays at its top value under a release and never moves below zero;
- a take lowers the count by exactly one;
- a release leaves the parked set empty, and a wake strobe never carries an empty set;
- valid data and the parked flag are never high together;
- queue mode freezes the count.

Only the bench scenarios can show the following, because each depends on values traced across several operations:
- the exact values returned;
- which ids are released;
- the write-before-read ordering of a simultaneous take and release;
- that raw-view and unused-view writes have no lasting effect.

// File: rtl/sem_pkg.sv
package sem_pkg;
    localparam int VIEW_W = 4;
    localparam logic [VIEW_W-1:0] VIEW_RAW    = 4'd0;
    localparam logic [VIEW_W-1:0] VIEW_PV_WAIT = 4'd4;
    localparam logic [VIEW_W-1:0] VIEW_PV_POLL = 4'd5;

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_DATA   = 2'd1,
        RSP_PARKED = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/sem_op_decode.sv
module sem_op_decode
    import sem_pkg::*;
(
    input  logic              queue_mode_i,
    input  logic [VIEW_W-1:0] view_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output logic              take_o,
    output logic              give_o,
    output logic              wait_o,
    output logic              raw_rd_o
);
    logic pv_view;

    always_comb begin
        pv_view  = (view_i == VIEW_PV_WAIT) || (view_i == VIEW_PV_POLL);
        take_o   = rd_i && pv_view && !queue_mode_i;
        give_o   = wr_i && pv_view && !queue_mode_i;
        wait_o   = (view_i == VIEW_PV_WAIT);
        raw_rd_o = rd_i && (view_i == VIEW_RAW);
    end
endmodule

// File: rtl/sem_counter.sv
module sem_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             give_i,
    input  logic             wait_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] seen_o,
    output logic             park_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] after_give;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        after_give = (give_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
        cnt_d      = (take_i && after_give != '0) ? after_give - 1'b1 : after_give;
        park_o     = take_i && wait_i && (after_give == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign seen_o = after_give;

    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (give_i && !take_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !give_i) |=> cnt_q == '0);
    a_r2_take_one: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !give_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sem_park_set.sv
module sem_park_set #(
    parameter int ID_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 give_i,
    input  logic                 park_i,
    input  logic [ID_W-1:0]      id_i,
    output logic                 wake_o,
    output logic [(1<<ID_W)-1:0] wake_set_o
);
    localparam int SET_W = 1 << ID_W;

    logic [SET_W-1:0] set_q;
    logic [SET_W-1:0] set_d;

    always_comb begin
        set_d = give_i ? '0 : set_q;
        if (park_i) set_d = set_d | (SET_W'(1) << id_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q      <= '0;
            wake_o     <= 1'b0;
            wake_set_o <= '0;
        end else begin
            set_q      <= set_d;
            wake_o     <= give_i && (set_q != '0);
            wake_set_o <= give_i ? set_q : '0;
        end
    end

    a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        give_i |=> set_q == '0);
    a_r6_wake_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> wake_set_o != '0);
    a_r4_parked_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (park_i && !give_i) |=> set_q[$past(id_i)]);
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ID_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 queue_mode_i,
    input  logic [3:0]           view_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic [ID_W-1:0]      req_id_i,
    output logic                 rsp_valid_o,
    output logic [CNT_W-1:0]     rsp_data_o,
    output logic                 parked_o,
    output logic                 wake_o,
    output logic [(1<<ID_W)-1:0] wake_set_o
);
    logic             take, give, wait_view, raw_rd, park;
    logic [CNT_W-1:0] cnt, seen, rdata_c;
    rsp_state_e       state_q, state_d;
    logic [CNT_W-1:0] data_q;

    sem_op_decode u_dec (
        .queue_mode_i(queue_mode_i), .view_i(view_i), .rd_i(rd_i), .wr_i(wr_i),
        .take_o(take), .give_o(give), .wait_o(wait_view), .raw_rd_o(raw_rd)
    );

    sem_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .take_i(take), .give_i(give), .wait_i(wait_view),
        .cnt_o(cnt), .seen_o(seen), .park_o(park)
    );

    sem_park_set #(.ID_W(ID_W)) u_park (
        .clk(clk), .rst_n(rst_n), .give_i(give), .park_i(park), .id_i(req_id_i),
        .wake_o(wake_o), .wake_set_o(wake_set_o)
    );

    always_comb begin
        if (raw_rd)    rdata_c = cnt;
        else if (take) rdata_c = seen;
        else           rdata_c = '0;
        if (!rd_i)     state_d = RSP_IDLE;
        else if (park) state_d = RSP_PARKED;
        else           state_d = RSP_DATA;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= (state_d == RSP_DATA) ? rdata_c : '0;
        end
    end

    always_comb begin
        rsp_valid_o = 1'b0;
        parked_o    = 1'b0;
        rsp_data_o  = '0;
        unique case (state_q)
            RSP_IDLE:   ;
            RSP_DATA:   begin rsp_valid_o = 1'b1; rsp_data_o = data_q; end
            RSP_PARKED: parked_o = 1'b1;
            default:    ;
        endcase
    end

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid_o, parked_o}));
    a_r1_quiet_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rsp_valid_o && !parked_o);
    a_r8_queue_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        queue_mode_i |=> cnt == $past(cnt));
endmodule

// File: tb/sim_sem_cell.sv
module sim_sem_cell;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        qm = 1'b0;
    logic [3:0]  view = 4'd0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [5:0]  id = 6'd0;
    logic        rsp_valid, parked, wake;
    logic [15:0] rsp_data;
    logic [63:0] wake_set;

    int compared = 0, mismatched = 0;
    int          m_cnt = 0;
    logic [63:0] m_set = '0;
    logic        e_valid, e_parked, e_wake;
    logic [15:0] e_data;
    logic [63:0] e_set;

    always #(PERIOD/2) clk = ~clk;

    sem_cell u0 (
        .clk(clk), .rst_n(rst_n), .queue_mode_i(qm), .view_i(view), .rd_i(rd),
        .wr_i(wr), .req_id_i(id), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .parked_o(parked), .wake_o(wake), .wake_set_o(wake_set)
    );

    task automatic check1(string tag, string what, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(string tag, logic [3:0] v, logic r, logic w, logic [5:0] i, logic q);
        bit pv, dov, dop;
        int cv;
        view = v; rd = r; wr = w; id = i; qm = q;
        pv  = (v == 4'd4) || (v == 4'd5);
        dov = w && pv && !q;
        dop = r && pv && !q;
        cv  = (dov && m_cnt < 65535) ? m_cnt + 1 : m_cnt;
        e_valid = 1'b0; e_parked = 1'b0; e_data = '0;
        e_wake = dov && (m_set != 0);
        e_set  = dov ? m_set : '0;
        if (dov) m_set = '0;
        if (r) begin
            if (dop) begin
                if (cv > 0) begin e_valid = 1'b1; e_data = 16'(cv); cv = cv - 1; end
                else if (v == 4'd4) begin e_parked = 1'b1; m_set[i] = 1'b1; end
                else e_valid = 1'b1;
            end else if (v == 4'd0) begin
                e_valid = 1'b1; e_data = 16'(m_cnt);
            end else e_valid = 1'b1;
        end
        m_cnt = cv;
        @(posedge clk);
        @(negedge clk);
        check1(tag, "rsp_valid", rsp_valid, e_valid);
        check1(tag, "parked", parked, e_parked);
        check1(tag, "rsp_data", rsp_data, e_data);
        check1(tag, "wake", wake, e_wake);
        check1(tag, "wake_set", wake_set, e_set);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc("R1", 4'd0, 0, 0, 0, 0);
        cyc("R9", 4'd0, 1, 0, 0, 0);
        cyc("R5", 4'd4, 0, 1, 1, 0);
        cyc("R5", 4'd5, 0, 1, 2, 0);
        cyc("R5", 4'd4, 0, 1, 3, 0);
        cyc("R9", 4'd0, 1, 0, 0, 0);
        cyc("R2", 4'd5, 1, 0, 4, 0);
        cyc("R2", 4'd4, 1, 0, 4, 0);
        cyc("R2", 4'd4, 1, 0, 4, 0);
        cyc("R3", 4'd5, 1, 0, 9, 0);
        cyc("R3", 4'd0, 1, 0, 0, 0);
        cyc("R4", 4'd4, 1, 0, 7, 0);
        cyc("R4", 4'd4, 1, 0, 33, 0);
        cyc("R9", 4'd0, 0, 1, 0, 0);
        cyc("R9", 4'd0, 1, 0, 0, 0);
        cyc("R6", 4'd5, 0, 1, 0, 0);
        cyc("R6", 4'd4, 0, 1, 0, 0);
        cyc("R7", 4'd5, 1, 1, 0, 0);
        cyc("R7", 4'd0, 1, 0, 0, 0);
        cyc("R2", 4'd4, 1, 0, 0, 0);
        cyc("R2", 4'd4, 1, 0, 0, 0);
        cyc("R4", 4'd4, 1, 0, 2, 0);
        cyc("R7", 4'd4, 1, 1, 5, 0);
        cyc("R7", 4'd0, 1, 0, 0, 0);
        cyc("R5", 4'd4, 0, 1, 0, 0);
        cyc("R8", 4'd4, 1, 0, 0, 1);
        cyc("R8", 4'd5, 0, 1, 0, 1);
        cyc("R8", 4'd4, 1, 0, 63, 1);
        cyc("R8", 4'd0, 1, 0, 0, 0);
        cyc("R10", 4'd2, 1, 0, 0, 0);
        cyc("R10", 4'd7, 0, 1, 0, 0);
        cyc("R10", 4'd15, 1, 1, 0, 0);
        cyc("R10", 4'd0, 1, 0, 0, 0);
        for (int k = 0; k < 65540; k++) cyc("R5", 4'd5, 0, 1, 0, 0);
        cyc("R5", 4'd0, 1, 0, 0, 0);
        cyc("R7", 4'd4, 1, 1, 0, 0);
        cyc("R7", 4'd0, 1, 0, 0, 0);
        cyc("R1", 4'd0, 0, 0, 0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule